// File: doc/BRIEF.md
# Dual Countdown Timer with Read-Acknowledged Interrupts

This block provides two countdown timers and a free-running tick counter. All three sit behind a small word-addressed register bus. Both timers and the free counter advance on a shared `tick` strobe, which is a one-cycle enable from an external prescaler, such as a 1 MHz pulse.

Each timer has one 32-bit configuration word. This word holds the reload count, a repeat flag and a run flag. Writing the word loads the count into the timer's counter. From then on, each tick lowers the counter while the timer runs. On the tick that would take the counter to zero, the timer expires and raises its interrupt line. In repeat mode the timer then reloads the count. In one-shot mode it clears its own run flag. The interrupt stays high until software reads that timer's present-value word, which acknowledges it.

Word map (index on `bus_addr`): 0 is the timer 0 configuration, 1 is the timer 0 present value, 2 is the timer 1 configuration, 3 is the timer 1 present value, and 4 is the free-running count. Indices 5 to 7 read as zero.

Top module: `dual_tick_timer`

## Requirements
- R1: A write to a configuration word stores all 32 bits for read-back and loads the counter with bits 28..0. Bit 29 is kept but has no effect on counting.
- R2: Each `tick` lowers the counter by one while bit 31 (run) is set. While run is clear, the counter holds its value.
- R3: With count N ≥ 1, the timer expires on the N-th tick after the load, and its interrupt rises in the cycle after that tick. A count of 0 expires on the first tick.
- R4: With bit 30 (repeat) set, an expiry reloads the counter with the count field and leaves run set, so the timer expires again every N ticks.
- R5: With repeat clear, an expiry leaves the counter at 0 and clears run (bit 31 then reads back as 0).
- R6: A raised interrupt stays high until its timer's present-value word is read. That read drops it in the next cycle.
- R7: If a present-value read and an expiry of the same timer fall in the same cycle, the interrupt stays high.
- R8: The free-running counter (USEC_W bits, zero-extended on read) rises by one on every tick and wraps to zero. Writes to its word have no effect.
- R9: The timers are independent. Reading one timer's present value never clears the other timer's interrupt.
- R10: `bus_rdata` is loaded on the edge where `bus_rd` is sampled and holds the value of the addressed word before that edge. Unmapped indices read as zero.
- R11: After reset, every word reads as zero and both interrupts are low.
- R12: A configuration write in the same cycle as a tick wins. The counter takes the new count, not a decremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Word index |
| bus_rd | input | 1 | Read strobe (has side effects on present-value words) |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick | input | 1 | Shared one-cycle count strobe |
| irq_t0 | output | 1 | Timer 0 interrupt |
| irq_t1 | output | 1 | Timer 1 interrupt |

## Verification
The bench sweeps counts 0 to 5 in both one-shot and repeat mode. It checks the counter value after every tick, so a design that is off by one fires a tick early or late, or shows the wrong remaining count. It drives a read acknowledge into the exact expiry cycle: a design that gave the clear priority would lose that interrupt. It also drives a configuration write into a tick cycle: a design that let the tick win would show a count one lower than written. The bench also checks that bit 29 has no effect, that the free counter wraps, and that one timer's acknowledge does not clear the other.

// File: rtl/tmr_pkg.sv
// Package: shared constants for the dual countdown timer.
// Assumes a 32-bit register word whose top three bits are control flags.
package tmr_pkg;
    localparam int WORD_W  = 32;
    localparam int RUN_BIT = 31;
    localparam int RPT_BIT = 30;
    localparam int RSV_BIT = 29;
    localparam int CNT_W   = RSV_BIT;   // bits 28..0 hold the count
    localparam int N_TMR   = 2;

    // word indices on the register bus
    localparam int IDX_CFG0 = 0;
    localparam int IDX_VAL0 = 1;
    localparam int IDX_CFG1 = 2;
    localparam int IDX_VAL1 = 3;
    localparam int IDX_FREE = 4;
endpackage

// File: rtl/tmr_channel.sv
// One countdown channel. It holds the configuration word, the live counter
// and the pending interrupt. Assumes tick is a single-cycle strobe and that
// cfg_wr and val_rd are already decoded for this channel.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              val_rd,
    output logic [WORD_W-1:0] cfg_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              irq
);
    logic run;
    logic reload;
    logic last_step;
    logic expire;

    assign run       = cfg_q[RUN_BIT];
    assign reload    = cfg_q[RPT_BIT];
    assign last_step = (cnt_q <= CNT_W'(1));
    assign expire    = tick && run && !cfg_wr && last_step;

    // Configuration word: written by software, run flag dropped after one-shot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= wdata;
        end else if (expire && !reload) begin
            cfg_q[RUN_BIT] <= 1'b0;
        end
    end

    // Counter: load on write, reload or park on expiry, otherwise step down per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cfg_wr) begin
            cnt_q <= wdata[CNT_W-1:0];
        end else if (expire) begin
            cnt_q <= reload ? cfg_q[CNT_W-1:0] : '0;
        end else if (tick && run) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Pending interrupt: expiry sets it and wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (expire) begin
            irq <= 1'b1;
        end else if (val_rd) begin
            irq <= 1'b0;
        end
    end

    p_expire_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !cfg_wr && !last_step) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cfg_wr) |=> $stable(cnt_q));
    p_oneshot_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !reload) |=> (!cfg_q[RUN_BIT] && cnt_q == '0));
    p_repeat_reloads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload) |=> (cfg_q[RUN_BIT] && cnt_q == $past(cfg_q[CNT_W-1:0])));
    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !val_rd) |=> irq);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (val_rd && !expire) |=> !irq);
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cnt_q == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/tmr_free_counter.sv
// Free-running tick counter of USEC_W bits that wraps at its top.
// Assumes tick is a single-cycle strobe. The counter has no write path.
module tmr_free_counter #(
    parameter int USEC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [USEC_W-1:0] count
);
    // Counts every tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= count + USEC_W'(1);
        end
    end

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/tmr_bus_decode.sv
// Bus decode: turns the word index and strobes into per-channel write and
// acknowledge selects. Assumes one access per cycle.
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic [N_TMR-1:0]  cfg_wr,
    output logic [N_TMR-1:0]  val_rd
);
    // One decode pair per channel; the config word sits at 2*i, the value word at 2*i+1.
    for (genvar i = 0; i < N_TMR; i++) begin : g_sel
        localparam int CFG_IDX = 2 * i;
        localparam int VAL_IDX = 2 * i + 1;
        assign cfg_wr[i] = wr && (addr == ADDR_W'(CFG_IDX));
        assign val_rd[i] = rd && (addr == ADDR_W'(VAL_IDX));
    end
endmodule

// File: rtl/dual_tick_timer.sv
// Top level: two countdown channels, a free-running tick counter and a
// registered read port. Assumes tick comes from an external prescaler and
// that software acknowledges an interrupt by reading the present-value word.
module dual_tick_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int USEC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              irq_t0,
    output logic              irq_t1
);
    logic [N_TMR-1:0]  cfg_wr;
    logic [N_TMR-1:0]  val_rd;
    logic [N_TMR-1:0]  irq_vec;
    logic [WORD_W-1:0] cfg_w [N_TMR];
    logic [CNT_W-1:0]  cnt_w [N_TMR];
    logic [USEC_W-1:0] free_cnt;
    logic [WORD_W-1:0] rd_mux;

    tmr_bus_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .cfg_wr (cfg_wr),
        .val_rd (val_rd)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        tmr_channel i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .cfg_wr (cfg_wr[i]),
            .wdata  (bus_wdata),
            .val_rd (val_rd[i]),
            .cfg_q  (cfg_w[i]),
            .cnt_q  (cnt_w[i]),
            .irq    (irq_vec[i])
        );
    end

    tmr_free_counter #(.USEC_W(USEC_W)) i_free (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (free_cnt)
    );

    assign irq_t0 = irq_vec[0];
    assign irq_t1 = irq_vec[1];

    // Read selection for the addressed word.
    always_comb begin
        case (bus_addr)
            ADDR_W'(IDX_CFG0): rd_mux = cfg_w[0];
            ADDR_W'(IDX_VAL0): rd_mux = WORD_W'(cnt_w[0]);
            ADDR_W'(IDX_CFG1): rd_mux = cfg_w[1];
            ADDR_W'(IDX_VAL1): rd_mux = WORD_W'(cnt_w[1]);
            ADDR_W'(IDX_FREE): rd_mux = WORD_W'(free_cnt);
            default:           rd_mux = '0;
        endcase
    end

    // Registered read data, captured on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > ADDR_W'(IDX_FREE)) |=> (bus_rdata == '0));
    p_rdata_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    p_ack_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_t1 && !val_rd[1]) |=> irq_t1);
endmodule

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        irq_t0, irq_t1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int free_exp = 0;
    logic [31:0] rv;

    localparam logic [31:0] RUN = 32'h8000_0000;
    localparam logic [31:0] RPT = 32'h4000_0000;

    always #5 clk = ~clk;

    dual_tick_timer #(.ADDR_W(3), .USEC_W(8)) i_dual_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .irq_t0(irq_t0), .irq_t1(irq_t1)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_word(logic [2:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_word(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        free_exp = (free_exp + 1) % 256;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 irq0", {31'd0, irq_t0}, 32'd0);
        chk("R11 irq1", {31'd0, irq_t1}, 32'd0);
        for (int a = 0; a < 5; a++) begin
            rd_word(3'(a), rv); chk("R11 word", rv, 32'd0);
        end

        // Sweep over counts and modes on timer 0 (R1..R6)
        for (int rpt = 0; rpt < 2; rpt++) begin
            for (int n = 0; n < 6; n++) begin
                logic [31:0] w;
                int per;
                w = RUN | (rpt != 0 ? RPT : 32'd0) | 32'(n);
                per = (n == 0) ? 1 : n;
                wr_word(3'd0, w);
                rd_word(3'd0, rv); chk("R1 cfg readback", rv, w);
                rd_word(3'd1, rv); chk("R1 load", rv, 32'(n));
                for (int k = 1; k <= per; k++) begin
                    pulse_tick();
                    if (k < per) begin
                        chk("R3 early irq", {31'd0, irq_t0}, 32'd0);
                        rd_word(3'd1, rv); chk("R2 step", rv, 32'(n - k));
                    end else begin
                        chk("R3 expiry irq", {31'd0, irq_t0}, 32'd1);
                    end
                end
                chk("R9 other idle", {31'd0, irq_t1}, 32'd0);
                repeat (2) @(negedge clk);
                chk("R6 sticky", {31'd0, irq_t0}, 32'd1);
                rd_word(3'd0, rv);
                if (rpt != 0) chk("R4 run kept", rv, w);
                else          chk("R5 run cleared", rv, w & ~RUN);
                rd_word(3'd1, rv);
                if (rpt != 0) chk("R4 reload", rv, 32'(n));
                else          chk("R5 parked", rv, 32'd0);
                chk("R6 ack", {31'd0, irq_t0}, 32'd0);
                if (rpt != 0) begin
                    for (int k = 1; k <= per; k++) pulse_tick();
                    chk("R4 second period", {31'd0, irq_t0}, 32'd1);
                    rd_word(3'd1, rv);
                end else begin
                    pulse_tick();
                    chk("R5 no refire", {31'd0, irq_t0}, 32'd0);
                end
                wr_word(3'd0, 32'd0);
            end
        end

        // R2: stopped timer holds
        wr_word(3'd2, 32'd7);
        repeat (3) pulse_tick();
        rd_word(3'd3, rv); chk("R2 hold", rv, 32'd7);
        chk("R2 no irq", {31'd0, irq_t1}, 32'd0);

        // R1: bit 29 has no effect
        wr_word(3'd0, 32'hA000_0003);
        repeat (3) pulse_tick();
        chk("R1 reserved irq", {31'd0, irq_t0}, 32'd1);
        rd_word(3'd0, rv); chk("R1 reserved kept", rv, 32'h2000_0003);
        rd_word(3'd1, rv);

        // R9: independent timers
        wr_word(3'd0, RUN | RPT | 32'd2);
        wr_word(3'd2, RUN | RPT | 32'd3);
        repeat (6) pulse_tick();
        chk("R9 both a", {31'd0, irq_t0}, 32'd1);
        chk("R9 both b", {31'd0, irq_t1}, 32'd1);
        rd_word(3'd1, rv);
        chk("R9 ack a", {31'd0, irq_t0}, 32'd0);
        chk("R9 b kept", {31'd0, irq_t1}, 32'd1);
        rd_word(3'd3, rv);
        chk("R9 ack b", {31'd0, irq_t1}, 32'd0);
        wr_word(3'd2, 32'd0);

        // R7: acknowledge in the expiry cycle
        wr_word(3'd0, RUN | RPT | 32'd1);
        pulse_tick();
        chk("R7 armed", {31'd0, irq_t0}, 32'd1);
        @(negedge clk); bus_addr = 3'd1; bus_rd = 1'b1; tick = 1'b1;
        @(negedge clk); bus_rd = 1'b0; tick = 1'b0;
        free_exp = (free_exp + 1) % 256;
        chk("R7 data", bus_rdata, 32'd1);
        chk("R7 irq kept", {31'd0, irq_t0}, 32'd1);
        rd_word(3'd1, rv);
        chk("R7 later ack", {31'd0, irq_t0}, 32'd0);

        // R12: write beats tick
        wr_word(3'd0, RUN | 32'd9);
        repeat (2) pulse_tick();
        rd_word(3'd1, rv); chk("R12 pre", rv, 32'd7);
        @(negedge clk); bus_addr = 3'd0; bus_wdata = RUN | 32'd3; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
        free_exp = (free_exp + 1) % 256;
        rd_word(3'd1, rv); chk("R12 new count", rv, 32'd3);
        wr_word(3'd0, 32'd0);

        // R8: free counter, write ignored, wrap
        rd_word(3'd4, rv); chk("R8 count", rv, 32'(free_exp));
        wr_word(3'd4, 32'h55);
        rd_word(3'd4, rv); chk("R8 write ignored", rv, 32'(free_exp));
        for (int k = 0; k < 300; k++) pulse_tick();
        rd_word(3'd4, rv); chk("R8 wrap", rv, 32'(free_exp));

        // R10: unmapped words
        for (int a = 5; a < 8; a++) begin
            rd_word(3'(a), rv); chk("R10 unmapped", rv, 32'd0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule